// File: doc/BRIEF.md
# Three-Input LUT Unit

This block evaluates an arbitrary three-input Boolean function across a whole data word. For every bit position it takes one bit from the old destination value, one from operand A and one from operand B. Those three bits form an index into an 8-entry truth table. The table is taken either from an immediate that arrives split into a 5-bit low part and a 3-bit high part, or from the low byte of a fourth operand C. Because the old destination value is an index source, the destination is read as well as written.

Two further forms exist. A whole-word test form reduces each operand to a zero/nonzero flag and returns a single result bit. A swizzle form builds the index from three byte components of A. It produces one result byte and writes that byte only into the byte lanes enabled by a 4-bit mask. Disabled lanes keep the old destination value.

The result is registered by default: one valid input gives one valid output a cycle later. With `OUT_REG` cleared, the unit is purely combinational. `W` must be at least 32.

Top module: `lut3_unit`

## Requirements
- R1: In bitwise form, result bit i equals table bit number {T[i],A[i],B[i]}, where T is the MSB of the index and B is the LSB. Table 0xF0 yields T, 0xCC yields A and 0xAA yields B.
- R2: When `variant[0]`=0 the table is {imm_hi, imm_lo}: imm_hi supplies table bits 7..5 and imm_lo supplies table bits 4..0.
- R3: When `variant[0]`=1 the table is `op_c[7:0]`. Bits of `op_c` above 7 have no effect on the result.
- R4: With `variant[1]`=0 and `mode`=2'b01, result bit 0 equals table bit {|T,|A,|B} and every higher result bit is 0. Modes 2'b00, 2'b10 and 2'b11 give the bitwise form.
- R5: With `variant[1]`=1 (swizzle), for i in 0..7 and every lane j whose `lane_mask[j]`=1, result bit 8j+i equals table bit {A[i],A[8+i],A[16+i]}. `mode` is ignored in this form.
- R6: In swizzle form, lanes whose mask bit is 0, and all bits from 32 upward, equal the corresponding bits of T.
- R7: `out_valid` is `in_valid` delayed by one cycle. When `in_valid` is 0, `result` holds its previous value.
- R8: After reset, `result` is 0 and `out_valid` is 0.
- R9: Table 0x96 gives T^A^B and table 0xE8 gives the bitwise majority of T, A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| variant | input | 2 | Bit 0: table from op_c; bit 1: swizzle form |
| mode | input | 2 | 2'b01 selects whole-word test; other values select bitwise |
| op_t | input | W | Old destination value, index MSB source |
| op_a | input | W | Operand A |
| op_b | input | W | Operand B, index LSB source |
| op_c | input | W | Register table source (low byte used) |
| imm_lo | input | 5 | Immediate table bits 4..0 |
| imm_hi | input | 3 | Immediate table bits 7..5 |
| lane_mask | input | 4 | Swizzle byte-lane write enables |
| out_valid | output | 1 | Result valid |
| result | output | W | Result word |

## Verification
Several properties are checked on every cycle. The valid pipeline and the hold of the result are covered. The zero upper bits in whole-word mode are covered, as is the preservation of masked-off lanes and of bits 32 and up in the swizzle form. An all-ones register table forcing an all-ones word is also checked. Only the bench scenarios can show that the correct table bit is picked for each index order, that the two immediate fields join in the right order, and the specific XOR and majority functions. The lane contents written by the swizzle also depend on those scenarios.

// File: rtl/lut3_unit.sv
module lut3_unit #(
  parameter int W       = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   variant,
  input  logic [1:0]   mode,
  input  logic [W-1:0] op_t,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [4:0]   imm_lo,
  input  logic [2:0]   imm_hi,
  input  logic [3:0]   lane_mask,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int LW    = 8;
  localparam int LANES = 4;
  localparam logic [1:0] MODE_WORD = 2'b01;

  logic [7:0]    tbl;
  logic [LW-1:0] swz;
  logic [W-1:0]  nxt;

  assign tbl = variant[0] ? op_c[7:0] : {imm_hi, imm_lo};

  always_comb begin
    for (int i = 0; i < LW; i++)
      swz[i] = tbl[{op_a[i], op_a[LW+i], op_a[2*LW+i]}];
  end

  always_comb begin
    nxt = op_t;
    if (variant[1]) begin
      for (int j = 0; j < LANES; j++)
        for (int i = 0; i < LW; i++)
          if (lane_mask[j]) nxt[j*LW+i] = swz[i];
    end else if (mode == MODE_WORD) begin
      nxt    = '0;
      nxt[0] = tbl[{|op_t, |op_a, |op_b}];
    end else begin
      for (int i = 0; i < W; i++)
        nxt[i] = tbl[{op_t[i], op_a[i], op_b[i]}];
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      logic [W-1:0] res_q;
      logic         vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q <= '0;
          vld_q <= 1'b0;
        end else begin
          vld_q <= in_valid;
          if (in_valid) res_q <= nxt;
        end
      end

      assign result    = res_q;
      assign out_valid = vld_q;

      AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
      AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R7
      AST_WORD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !variant[1] && mode == MODE_WORD |=> result[W-1:1] == '0); // R4
      AST_TABLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && variant == 2'b01 && mode != MODE_WORD && op_c[7:0] == 8'hFF
        |=> result == {W{1'b1}}); // R3

      for (genvar j = 0; j < LANES; j++) begin : g_lane_chk
        AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
          in_valid && variant[1] && !lane_mask[j]
          |=> result[j*LW +: LW] == $past(op_t[j*LW +: LW])); // R6
      end

      if (W > LANES*LW) begin : g_upper_chk
        AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
          in_valid && variant[1]
          |=> result[W-1:LANES*LW] == $past(op_t[W-1:LANES*LW])); // R6
      end
    end else begin : g_comb
      assign result    = nxt;
      assign out_valid = in_valid;
    end
  endgenerate
endmodule

// File: tb/sim_lut3_unit.sv
module sim_lut3_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  variant = '0;
  logic [1:0]  mode = '0;
  logic [63:0] op_t = '0, op_a = '0, op_b = '0, op_c = '0;
  logic [4:0]  imm_lo = '0;
  logic [2:0]  imm_hi = '0;
  logic [3:0]  lane_mask = '0;
  logic        out_valid;
  logic [63:0] result;

  int tests = 0;
  int fails = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_res = '0;
  bit          seen = 1'b0;

  always #10 clk = ~clk;

  lut3_unit #(.W(64), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .variant(variant),
    .mode(mode), .op_t(op_t), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .imm_lo(imm_lo), .imm_hi(imm_hi), .lane_mask(lane_mask),
    .out_valid(out_valid), .result(result));

  function automatic logic [63:0] ref_lut(input logic [63:0] t, a, b, c,
      input logic [7:0] imm, input logic [3:0] m, input logic [1:0] v, md);
    logic [7:0]  tb;
    logic [63:0] r;
    tb = v[0] ? c[7:0] : imm;
    r  = t;
    if (v[1]) begin
      for (int j = 0; j < 4; j++)
        for (int i = 0; i < 8; i++)
          if (m[j]) r[8*j+i] = tb[{a[i], a[8+i], a[16+i]}];
    end else if (md == 2'b01) begin
      r = '0;
      r[0] = tb[{|t, |a, |b}];
    end else begin
      for (int i = 0; i < 64; i++) r[i] = tb[{t[i], a[i], b[i]}];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] t, a, b, c, input logic [7:0] imm,
      input logic [3:0] m, input logic [1:0] v, md,
      input logic [63:0] exp, input string tag);
    @(negedge clk);
    op_t = t; op_a = a; op_b = b; op_c = c;
    imm_lo = imm[4:0]; imm_hi = imm[7:5];
    lane_mask = m; variant = v; mode = md; in_valid = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic sendm(input logic [63:0] t, a, b, c, input logic [7:0] imm,
      input logic [3:0] m, input logic [1:0] v, md, input string tag);
    send(t, a, b, c, imm, m, v, md, ref_lut(t, a, b, c, imm, m, v, md), tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    op_t = ~op_t; op_a = ~op_a; variant = ~variant;
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check("R7 unexpected out_valid", 64'd1, 64'd0);
        else check(tag_q.pop_front(), result, exp_q.pop_front());
        last_res = result;
        seen = 1'b1;
      end else if (seen) begin
        check("R7 hold while idle", result, last_res);
      end
    end
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] t0, a0, b0;
    t0 = 64'hF0F0_CCCC_1234_5678;
    a0 = 64'hFF00_AAAA_0F0F_9ABC;
    b0 = 64'h0FF0_5555_3C3C_DEF0;
    repeat (3) @(negedge clk);
    check("R8 reset result", result, 64'd0);
    check("R8 reset out_valid", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;

    send(t0, a0, b0, 64'd0, 8'hF0, 4'h0, 2'b00, 2'b00, t0, "R1 table F0 gives T");
    send(t0, a0, b0, 64'd0, 8'hCC, 4'h0, 2'b00, 2'b00, a0, "R1 table CC gives A");
    send(t0, a0, b0, 64'd0, 8'hAA, 4'h0, 2'b00, 2'b00, b0, "R1 table AA gives B");
    send(t0, a0, b0, 64'd0, 8'h96, 4'h0, 2'b00, 2'b00, t0 ^ a0 ^ b0, "R9 xor3");
    send(t0, a0, b0, 64'd0, 8'hE8, 4'h0, 2'b00, 2'b00,
         (t0 & a0) | (t0 & b0) | (a0 & b0), "R9 majority");
    idle(); idle();
    send(64'hFFFF_FFFF_FFFF_FFFF, '1, '1, 64'd0, 8'h80, 4'h0, 2'b00, 2'b00,
         '1, "R2 imm_hi bit 7");
    send(64'd0, 64'd0, 64'd0, 64'd0, 8'h01, 4'h0, 2'b00, 2'b00,
         '1, "R2 imm_lo bit 0");
    send(64'd0, '1, 64'd0, 64'd0, 8'h04, 4'h0, 2'b00, 2'b00,
         '1, "R2 imm_lo bit 2");
    send(t0, a0, b0, 64'h1234_5678_9ABC_DE96, 8'h00, 4'h0, 2'b01, 2'b00,
         t0 ^ a0 ^ b0, "R3 register table xor");
    send(t0, a0, b0, 64'hFFFF_0000_5555_AA96, 8'h00, 4'h0, 2'b01, 2'b00,
         t0 ^ a0 ^ b0, "R3 upper C bits ignored");
    send(t0, a0, b0, 64'hAAAA_0000_0000_00FF, 8'h00, 4'h0, 2'b01, 2'b11,
         '1, "R3 table FF all ones (mode 11 bitwise)");
    send(64'd0, 64'h5, 64'd0, 64'd0, 8'h04, 4'h0, 2'b00, 2'b01,
         64'd1, "R4 whole-word idx 2");
    send(64'd0, 64'd0, 64'd0, 64'd0, 8'h04, 4'h0, 2'b00, 2'b01,
         64'd0, "R4 whole-word idx 0");
    send(64'h8000_0000_0000_0000, 64'd0, 64'h10, 64'h20, 8'h00, 4'h0, 2'b01, 2'b01,
         64'd1, "R4 whole-word idx 5 register table");
    send(t0, a0, b0, 64'd0, 8'hCC, 4'h0, 2'b00, 2'b10, a0, "R4 mode 10 is bitwise");
    idle();
    send(64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_FF00, 64'd0, 64'd0, 8'h04,
         4'b0101, 2'b10, 2'b01, 64'h0123_4567_89FF_CDFF, "R5 swizzle lanes 0,2");
    send(64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_FF00, 64'd0, 64'd0, 8'h04,
         4'b0000, 2'b10, 2'b00, 64'h0123_4567_89AB_CDEF, "R6 swizzle no lanes");
    sendm(t0, 64'h0000_0000_00F0_CC5A, b0, 64'h0000_0000_0000_0096, 8'h00,
          4'b1111, 2'b11, 2'b00, "R5 swizzle all lanes register table");
    sendm(t0, 64'hDEAD_BEEF_0033_55AA, b0, 64'd0, 8'hE8,
          4'b1010, 2'b10, 2'b00, "R6 swizzle lanes 1,3 keep others");
    idle(); idle(); idle();
    for (int k = 0; k < 8; k++) begin
      logic [63:0] tk, ak, bk;
      tk = t0 ^ (64'h1111_1111_1111_1111 << k);
      ak = a0 + 64'(k * 977);
      bk = {b0[31:0], b0[63:32]} ^ 64'(k);
      sendm(tk, ak, bk, 64'(k * 37), 8'(k * 29 + 3), 4'(k), 2'(k), 2'(k >> 1),
            "R1 mixed pattern");
    end
    idle(); idle(); idle();
    check("R7 all expected results seen", 64'(exp_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule